// File: doc/BRIEF.md
# Dual-Run Fault-Checking Reorder Buffer

This block is the retirement buffer of an out-of-order core. It checks for transient faults by running every instruction twice on the functional units the core already has. Instructions enter in program order and each one is given a slot tag. The block offers a waiting slot to a functional-unit port and then takes the tagged result back. It offers the same slot a second time and compares the new result with the one it stored from the first run. Only a slot whose two runs agree becomes eligible to retire, and slots retire strictly in order from the head.

The redundancy sits inside each slot, so the slot count stays the same as in a plain buffer. Each slot holds a run marker, a saved first result and a saved second result. The second result is only used when the third run has to break a tie. A static configuration input selects what happens after a disagreement. In vote mode (0) the slot runs a third time and keeps the value that two of the three runs share. In restart mode (1) the slot runs again from its first run. If all three runs differ in vote mode, a fault flag goes high for one cycle and the slot restarts from its first run.

Top module: `dual_run_rob`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready_o`=1, `alloc_tag_o`=0, and `issue_valid_o`, `commit_valid_o` and `fault_o` are all 0.
- R2: Allocation hands out tags 0,1,2,… in order, wrapping from 15 back to 0. `alloc_ready_o` is 1 exactly while fewer than 16 slots are outstanding.
- R3: Every slot is offered for issue at least twice, with its allocation payload on `issue_payload_o`. When the first two results are equal, the slot commits that value after exactly two issues.
- R4: When several slots wait for issue, the oldest one in program order (the nearest to the head) is offered first.
- R5: Commits leave in allocation order, at most one per cycle. A finished younger slot waits while the head slot is still in its runs.
- R6: In vote mode (`cfg_reissue_i`=0), a mismatch causes exactly one third issue. The committed value is whichever of the first two results the third result equals.
- R7: In restart mode (`cfg_reissue_i`=1), a mismatch sends the slot back to its first run. It commits the first later pair that agrees, having used two issues per attempt.
- R8: In vote mode, if all three results differ, `fault_o` is high for one cycle and the slot restarts from its first run. In restart mode `fault_o` never rises.
- R9: An allocation and a commit in the same cycle both take effect, and the outstanding count is unchanged.
- R10: A writeback whose tag names a slot that is not awaiting a result is ignored. The empty buffer offers nothing and commits nothing afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_reissue_i | input | 1 | Recovery mode: 0 vote on third run, 1 restart |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_payload_i | input | PAY_W | Instruction payload stored in the slot |
| alloc_ready_o | output | 1 | A free slot exists |
| alloc_tag_o | output | TAG_W | Tag the next allocation receives |
| issue_valid_o | output | 1 | A slot is offered to the functional unit |
| issue_tag_o | output | TAG_W | Offered slot |
| issue_payload_o | output | PAY_W | Payload of the offered slot |
| issue_grant_i | input | 1 | Functional unit takes the offer this cycle |
| wb_valid_i | input | 1 | Result writeback |
| wb_tag_i | input | TAG_W | Slot the result belongs to |
| wb_data_i | input | DATA_W | Result value |
| commit_valid_o | output | 1 | Head slot retires this cycle |
| commit_tag_o | output | TAG_W | Retiring slot |
| commit_data_o | output | DATA_W | Agreed result |
| fault_o | output | 1 | Three-way disagreement seen |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is allocation and retirement. A long stream of clean instructions is run with the grant always given, so new tags enter while old ones leave. The outstanding count the bench keeps must then keep matching `alloc_ready_o`, and the bench records cycles in which both happened. The second pair is a writeback to one slot and an issue of a different slot. It comes from the one-cycle unit model, which returns results while the next offers are granted. Every commit is judged against a scoreboard entry computed from the injected error pattern: the tag, the value and the issue count.

// File: rtl/dual_run_rob_pkg.sv
package dual_run_rob_pkg;

  typedef enum logic [1:0] {
    SLOT_FREE,
    SLOT_WAIT_ISSUE,
    SLOT_IN_FLIGHT,
    SLOT_DONE
  } slot_st_e;

  // run marker: first / second run, plus the tie-break run of vote mode
  typedef enum logic [1:0] {
    RUN_FIRST,
    RUN_SECOND,
    RUN_TIE
  } run_e;

  typedef enum logic [1:0] {
    V_STORE_FIRST,
    V_STORE_SECOND,
    V_AGREE,
    V_RESTART
  } verdict_e;

  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/drr_pick.sv
module drr_pick #(
  parameter int DEPTH = 16,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] ready_i,
  input  logic [TAG_W-1:0] head_i,
  output logic             found_o,
  output logic [TAG_W-1:0] idx_o
);

  // scan from the head so the oldest waiting slot wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int p;
      p = (int'(head_i) + k) % DEPTH;
      if (!found_o && ready_i[p]) begin
        found_o = 1'b1;
        idx_o   = TAG_W'(p);
      end
    end
  end

endmodule

// File: rtl/drr_judge.sv
module drr_judge
  import dual_run_rob_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  run_e              run_i,
  input  logic [DATA_W-1:0] first_i,
  input  logic [DATA_W-1:0] second_i,
  input  logic [DATA_W-1:0] wb_i,
  input  logic              reissue_i,
  output verdict_e          act_o,
  output logic [DATA_W-1:0] pick_o,
  output logic              three_way_o
);

  function automatic logic same(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    return a == b;
  endfunction

  always_comb begin
    act_o       = V_STORE_FIRST;
    pick_o      = first_i;
    three_way_o = 1'b0;
    unique case (run_i)
      RUN_FIRST: act_o = V_STORE_FIRST;
      RUN_SECOND: begin
        if (same(wb_i, first_i)) act_o = V_AGREE;
        else if (reissue_i)      act_o = V_RESTART;
        else                     act_o = V_STORE_SECOND;
      end
      RUN_TIE: begin
        if (same(wb_i, first_i)) begin
          act_o  = V_AGREE;
          pick_o = first_i;
        end else if (same(wb_i, second_i)) begin
          act_o  = V_AGREE;
          pick_o = second_i;
        end else begin
          act_o       = V_RESTART;
          three_way_o = 1'b1;
        end
      end
      default: act_o = V_STORE_FIRST;
    endcase
  end

endmodule

// File: rtl/dual_run_rob.sv
module dual_run_rob
  import dual_run_rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int PAY_W  = 32,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_reissue_i,
  input  logic              alloc_valid_i,
  input  logic [PAY_W-1:0]  alloc_payload_i,
  output logic              alloc_ready_o,
  output logic [TAG_W-1:0]  alloc_tag_o,
  output logic              issue_valid_o,
  output logic [TAG_W-1:0]  issue_tag_o,
  output logic [PAY_W-1:0]  issue_payload_o,
  input  logic              issue_grant_i,
  input  logic              wb_valid_i,
  input  logic [TAG_W-1:0]  wb_tag_i,
  input  logic [DATA_W-1:0] wb_data_i,
  output logic              commit_valid_o,
  output logic [TAG_W-1:0]  commit_tag_o,
  output logic [DATA_W-1:0] commit_data_o,
  output logic              fault_o
);

  slot_st_e          st_q     [DEPTH];
  run_e              run_q    [DEPTH];
  logic [DATA_W-1:0] first_q  [DEPTH];
  logic [DATA_W-1:0] second_q [DEPTH];
  logic [PAY_W-1:0]  pay_q    [DEPTH];
  logic [TAG_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  count_q;
  logic              fault_q;

  // named internal events
  logic [DEPTH-1:0]  wait_vec;
  logic              alloc_fire, issue_fire, commit_fire, wb_hit;
  verdict_e          judge_act;
  logic [DATA_W-1:0] judge_pick;
  logic              judge_three_way;

  for (genvar g = 0; g < DEPTH; g++) begin : g_wait
    assign wait_vec[g] = (st_q[g] == SLOT_WAIT_ISSUE);
  end

  drr_pick #(.DEPTH(DEPTH)) pick_i (
    .ready_i (wait_vec),
    .head_i  (head_q),
    .found_o (issue_valid_o),
    .idx_o   (issue_tag_o)
  );

  drr_judge #(.DATA_W(DATA_W)) judge_i (
    .run_i       (run_q[wb_tag_i]),
    .first_i     (first_q[wb_tag_i]),
    .second_i    (second_q[wb_tag_i]),
    .wb_i        (wb_data_i),
    .reissue_i   (cfg_reissue_i),
    .act_o       (judge_act),
    .pick_o      (judge_pick),
    .three_way_o (judge_three_way)
  );

  assign alloc_ready_o   = (count_q != CNT_W'(DEPTH));
  assign alloc_tag_o     = tail_q;
  assign issue_payload_o = pay_q[issue_tag_o];
  assign commit_valid_o  = (st_q[head_q] == SLOT_DONE);
  assign commit_tag_o    = head_q;
  assign commit_data_o   = first_q[head_q];
  assign fault_o         = fault_q;

  assign alloc_fire  = alloc_valid_i && alloc_ready_o;
  assign issue_fire  = issue_valid_o && issue_grant_i;
  assign commit_fire = commit_valid_o;
  assign wb_hit      = wb_valid_i && (st_q[wb_tag_i] == SLOT_IN_FLIGHT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i]     <= SLOT_FREE;
        run_q[i]    <= RUN_FIRST;
        first_q[i]  <= '0;
        second_q[i] <= '0;
        pay_q[i]    <= '0;
      end
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      fault_q <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_fire && tail_q == TAG_W'(i)) begin
          st_q[i]  <= SLOT_WAIT_ISSUE;
          run_q[i] <= RUN_FIRST;
          pay_q[i] <= alloc_payload_i;
        end else if (commit_fire && head_q == TAG_W'(i)) begin
          st_q[i] <= SLOT_FREE;
        end else if (issue_fire && issue_tag_o == TAG_W'(i)) begin
          st_q[i] <= SLOT_IN_FLIGHT;
        end else if (wb_hit && wb_tag_i == TAG_W'(i)) begin
          unique case (judge_act)
            V_STORE_FIRST: begin
              first_q[i] <= wb_data_i;
              run_q[i]   <= RUN_SECOND;
              st_q[i]    <= SLOT_WAIT_ISSUE;
            end
            V_STORE_SECOND: begin
              second_q[i] <= wb_data_i;
              run_q[i]    <= RUN_TIE;
              st_q[i]     <= SLOT_WAIT_ISSUE;
            end
            V_AGREE: begin
              first_q[i] <= judge_pick;
              st_q[i]    <= SLOT_DONE;
            end
            default: begin
              run_q[i] <= RUN_FIRST;
              st_q[i]  <= SLOT_WAIT_ISSUE;
            end
          endcase
        end
      end
      if (alloc_fire)  tail_q <= TAG_W'(wrap_inc(int'(tail_q), DEPTH));
      if (commit_fire) head_q <= TAG_W'(wrap_inc(int'(head_q), DEPTH));
      count_q <= count_q + CNT_W'(alloc_fire) - CNT_W'(commit_fire);
      fault_q <= wb_hit && judge_three_way;
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  a_r9_alloc_commit_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && commit_fire) |=> count_q == $past(count_q));

  a_r4_offer_is_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o |-> st_q[issue_tag_o] == SLOT_WAIT_ISSUE);

  a_r5_head_steps: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid_o |=> head_q == TAG_W'(wrap_inc(int'($past(head_q)), DEPTH)));

  a_r3_agree_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_hit && judge_act == V_AGREE) |-> run_q[wb_tag_i] != RUN_FIRST);

  a_r8_fault_only_vote: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !cfg_reissue_i);

endmodule

// File: tb/dual_run_rob_tb_top.sv
module dual_run_rob_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_reissue = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [31:0] alloc_payload = '0;
  logic        alloc_ready;
  logic [3:0]  alloc_tag;
  logic        issue_valid;
  logic [3:0]  issue_tag;
  logic [31:0] issue_payload;
  logic        issue_grant = 1'b0;
  logic        wb_valid = 1'b0;
  logic [3:0]  wb_tag = '0;
  logic [31:0] wb_data = '0;
  logic        commit_valid;
  logic [3:0]  commit_tag;
  logic [31:0] commit_data;
  logic        fault;

  always #2 clk = ~clk;

  dual_run_rob dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_reissue_i(cfg_reissue),
    .alloc_valid_i(alloc_valid), .alloc_payload_i(alloc_payload),
    .alloc_ready_o(alloc_ready), .alloc_tag_o(alloc_tag),
    .issue_valid_o(issue_valid), .issue_tag_o(issue_tag),
    .issue_payload_o(issue_payload), .issue_grant_i(issue_grant),
    .wb_valid_i(wb_valid), .wb_tag_i(wb_tag), .wb_data_i(wb_data),
    .commit_valid_o(commit_valid), .commit_tag_o(commit_tag),
    .commit_data_o(commit_data), .fault_o(fault)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // scoreboard state
  typedef struct { logic [3:0] tag; logic [31:0] data; int runs; } exp_t;
  typedef struct { logic [3:0] tag; logic [31:0] data; int due; } pend_t;
  exp_t        exp_q[$];
  pend_t       pq[$];
  logic [31:0] base_of [16];
  logic [31:0] errs    [16][6];
  int          runs_seen [16];
  int          next_tag = 0;
  int          exp_faults = 0;
  int          seen_faults = 0;
  int          outst = 0;
  int          both_cnt = 0;
  int          cyc = 0;
  bit          gnt_en = 0;
  bit          inj_en = 0;
  logic [3:0]  inj_tag = '0;

  function automatic logic [31:0] run_val(input int t, input int k);
    return base_of[t] ^ ((k < 6) ? errs[t][k] : 32'h0);
  endfunction

  // expected outcome derived from the recovery rules (R3, R6, R7, R8)
  task automatic predict(input int t, input bit restart_mode,
                         output logic [31:0] val, output int runs, output int faults);
    int k;
    k = 0; faults = 0; val = '0; runs = 0;
    while (runs == 0) begin
      logic [31:0] a, b, c;
      a = run_val(t, k); b = run_val(t, k + 1);
      if (a == b) begin val = a; runs = k + 2; end
      else if (restart_mode) k = k + 2;
      else begin
        c = run_val(t, k + 2);
        if (c == a)      begin val = a; runs = k + 3; end
        else if (c == b) begin val = b; runs = k + 3; end
        else begin faults++; k = k + 3; end
      end
    end
  endtask

  task automatic do_alloc(input logic [31:0] b, input logic [31:0] e0, input logic [31:0] e1,
                          input logic [31:0] e2, input logic [31:0] e3,
                          input logic [31:0] e4, input logic [31:0] e5);
    exp_t x;
    int f;
    @(negedge clk);
    while (!alloc_ready) begin
      alloc_valid = 1'b0;
      @(negedge clk);
    end
    chk(alloc_tag == 4'(next_tag), "R2", "allocation tag order", 32'(alloc_tag), 32'(next_tag));
    base_of[alloc_tag] = b;
    errs[alloc_tag][0] = e0; errs[alloc_tag][1] = e1; errs[alloc_tag][2] = e2;
    errs[alloc_tag][3] = e3; errs[alloc_tag][4] = e4; errs[alloc_tag][5] = e5;
    runs_seen[alloc_tag] = 0;
    x.tag = alloc_tag;
    predict(int'(alloc_tag), cfg_reissue, x.data, x.runs, f);
    exp_faults += f;
    exp_q.push_back(x);
    alloc_payload = b;
    alloc_valid = 1'b1;
    next_tag = (next_tag + 1) % 16;
    @(posedge clk);
    #1 alloc_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (outst != 0 || pq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // outstanding bookkeeping at the active edge (R2, R9)
  always @(posedge clk) begin
    if (rst_n) begin
      if (alloc_valid && alloc_ready) outst++;
      if (commit_valid) outst--;
      if (alloc_valid && alloc_ready && commit_valid) both_cnt++;
    end
  end

  // functional-unit model: grants offers, returns results one cycle later
  always @(negedge clk) begin
    pend_t p;
    cyc++;
    if (!rst_n) begin
      issue_grant = 1'b0;
      wb_valid = 1'b0;
    end else begin
      if (inj_en) begin
        wb_valid = 1'b1; wb_tag = inj_tag; wb_data = 32'hDEAD_BEEF;
      end else if (pq.size() > 0 && pq[0].due <= cyc) begin
        p = pq.pop_front();
        wb_valid = 1'b1; wb_tag = p.tag; wb_data = p.data;
      end else begin
        wb_valid = 1'b0;
      end
      if (gnt_en && issue_valid) begin
        issue_grant = 1'b1;
        chk(issue_payload == base_of[issue_tag], "R3", "issue payload",
            issue_payload, base_of[issue_tag]);
        p.tag  = issue_tag;
        p.data = run_val(int'(issue_tag), runs_seen[issue_tag]);
        p.due  = cyc + 1;
        pq.push_back(p);
        runs_seen[issue_tag]++;
      end else begin
        issue_grant = 1'b0;
      end
    end
  end

  // monitor: compare commits with the scoreboard
  always @(negedge clk) begin
    exp_t x;
    if (rst_n) begin
      if (fault) seen_faults++;
      chk(alloc_ready == (outst < 16), "R2", "ready vs outstanding",
          32'(alloc_ready), 32'(outst < 16));
      if (commit_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "commit with empty scoreboard", 32'(commit_tag), 32'hFFFF_FFFF);
        end else begin
          x = exp_q.pop_front();
          chk(commit_tag == x.tag, "R5", "commit order", 32'(commit_tag), 32'(x.tag));
          chk(commit_data == x.data, "R3/R6/R7", "commit value", commit_data, x.data);
          chk(runs_seen[commit_tag] == x.runs, "R3/R6/R7", "issue count",
              32'(runs_seen[commit_tag]), 32'(x.runs));
        end
      end
    end
  end

  task automatic set_gnt(input bit v);
    @(posedge clk);
    #1 gnt_en = v;
  endtask

  initial begin
    for (int t = 0; t < 16; t++) begin
      base_of[t] = '0; runs_seen[t] = 0;
      for (int k = 0; k < 6; k++) errs[t][k] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(alloc_ready == 1'b1, "R1", "ready in reset", 32'(alloc_ready), 1);
    chk(alloc_tag == 4'd0, "R1", "tag in reset", 32'(alloc_tag), 0);
    chk(!issue_valid && !commit_valid && !fault, "R1", "idle outputs",
        {29'd0, issue_valid, commit_valid, fault}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10: stray writeback on an empty buffer
    @(posedge clk); #1 inj_tag = 4'd0; inj_en = 1'b1;
    @(posedge clk); #1 inj_en = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(!issue_valid && !commit_valid, "R10", "stray writeback ignored",
          {30'd0, issue_valid, commit_valid}, 0);
    end

    // R4: oldest waiting slot offered first
    for (int i = 0; i < 4; i++) do_alloc(32'h1000 + i, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(issue_valid && issue_tag == 4'd0, "R4", "oldest offered", 32'(issue_tag), 0);
    set_gnt(1);
    drain();

    // R6, R8: vote mode cases
    do_alloc(32'hA0A0_0001, 32'h0, 32'h1, 0, 0, 0, 0);          // third agrees with first
    do_alloc(32'hA0A0_0002, 32'h2, 32'h0, 0, 0, 0, 0);          // third agrees with second
    do_alloc(32'hA0A0_0003, 32'h1, 32'h2, 32'h4, 0, 0, 0);      // three-way, fault
    do_alloc(32'hA0A0_0004, 32'h8, 32'h8, 0, 0, 0, 0);          // common-mode pair
    drain();
    chk(seen_faults == exp_faults, "R8", "fault pulses vote", 32'(seen_faults), 32'(exp_faults));

    // R5: faulty head holds back clean younger slots
    do_alloc(32'hB000_0001, 32'h10, 32'h20, 32'h40, 32'h3, 32'h5, 0);
    do_alloc(32'hB000_0002, 0, 0, 0, 0, 0, 0);
    do_alloc(32'hB000_0003, 0, 0, 0, 0, 0, 0);
    drain();
    chk(seen_faults == exp_faults, "R8", "fault pulses stall", 32'(seen_faults), 32'(exp_faults));

    // R7: restart mode
    cfg_reissue = 1'b1;
    do_alloc(32'hC000_0001, 32'h1, 0, 0, 0, 0, 0);
    do_alloc(32'hC000_0002, 0, 32'h1, 32'h2, 0, 0, 0);
    do_alloc(32'hC000_0003, 32'h1, 32'h2, 32'h4, 0, 0, 0);
    drain();
    chk(seen_faults == exp_faults, "R8", "no fault in restart", 32'(seen_faults), 32'(exp_faults));
    cfg_reissue = 1'b0;

    // R2: fill, ready drops at sixteen outstanding
    set_gnt(0);
    for (int i = 0; i < 16; i++) do_alloc(32'hD000_0000 + i, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(!alloc_ready, "R2", "full buffer not ready", 32'(alloc_ready), 0);
    set_gnt(1);
    drain();

    // R9: long stream, allocations overlap commits; tags wrap
    for (int i = 0; i < 40; i++) do_alloc(32'hE000_0000 + i * 7, 0, 0, 0, 0, 0, 0);
    drain();
    chk(both_cnt > 0, "R9", "alloc and commit together", 32'(both_cnt), 1);
    chk(exp_q.size() == 0, "R5", "all commits seen", 32'(exp_q.size()), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'(cyc), 32'h0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule